// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns one 32-bit instruction word into the steering signals of a single-cycle integer datapath. It pulls the major opcode, the three-bit function field and the seven-bit function field out of their fixed positions, then decodes in two levels. The first level classifies the opcode and sets register write, operand-B source, memory read and write, the write-back source, and the branch and jump indicators. The second level looks at the function fields and picks the operation code for the arithmetic unit. Add and subtract share both the opcode and the three-bit field, so only the seven-bit field tells them apart.

The decoder has no storage and no clock. The fetch stage drives the word, and the register file, arithmetic unit, data memory port and next-address logic read the outputs in the same cycle. Immediate generation, hazard handling and system instructions belong to other blocks. An opcode outside the supported set makes every write and memory enable low, so the datapath changes no state.

Top module: `instr_decoder`

## Requirements
- R1: The opcode is taken from bits [6:0], the three-bit function field from bits [14:12] and the seven-bit function field from bits [31:25]. Bits [24:15] and [11:7] have no effect on any output.
- R2: Opcode 0110011 (register-register) gives reg_wr=1, b_imm=0, mem_rd=0, mem_wr=0, wb_sel=0 (arithmetic result), branch=0, jump=0, jump_reg=0.
- R3: For opcode 0110011, the three-bit function field maps to alu_op as follows: 000 gives 0 (add), or 1 (subtract) when the seven-bit field equals 0100000. 001 gives 2 (shift left), 010 gives 3 (signed less-than), 011 gives 4 (unsigned less-than) and 100 gives 5 (xor). 101 gives 6 (logical right shift), or 7 (arithmetic right shift) when the seven-bit field equals 0100000. 110 gives 8 (or) and 111 gives 9 (and). Any other seven-bit value behaves like 0000000.
- R4: Opcode 0010011 (register-immediate) gives reg_wr=1, b_imm=1, wb_sel=0, and no memory, branch or jump. alu_op follows the R3 map, except that the seven-bit field is ignored for every function value other than 101. Function 000 therefore always gives add.
- R5: Opcode 0000011 (load) gives mem_rd=1, b_imm=1, reg_wr=1, wb_sel=1 (memory data), alu_op=0 and mem_wr=0.
- R6: Opcode 0100011 (store) gives mem_wr=1, b_imm=1, reg_wr=0, mem_rd=0, alu_op=0.
- R7: Opcode 1100011 (conditional branch) gives reg_wr=0, b_imm=0 and no memory access. Function values 000 and 001 give branch=1 with alu_op=10 (equality compare). Values 100 and 101 give branch=1 with alu_op=11 (signed compare). Values 110 and 111 give branch=1 with alu_op=12 (unsigned compare). Values 010 and 011 give branch=0 and alu_op=0.
- R8: Opcode 1101111 (direct jump) gives jump=1, jump_reg=0, reg_wr=1, wb_sel=2 (address of the next instruction), b_imm=0, alu_op=0, and no memory access.
- R9: Opcode 1100111 (register-relative jump) gives jump=1, jump_reg=1, reg_wr=1, wb_sel=2, b_imm=1, alu_op=0, and no memory access.
- R10: Any other opcode drives every output to zero: reg_wr, b_imm, mem_rd, mem_wr, branch, jump, jump_reg, wb_sel=0 and alu_op=0.
- R11: mem_rd and mem_wr are never high together, and branch and jump are never high together.
- R12: The outputs depend only on the present instruction word, with no register on the path, so a new word is fully decoded within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| reg_wr | output | 1 | Write the destination register |
| b_imm | output | 1 | Second operand comes from the immediate, not the register |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| wb_sel | output | 2 | Write-back source: 0 arithmetic, 1 memory, 2 next address |
| branch | output | 1 | Conditional branch; redirect when the compare holds |
| jump | output | 1 | Unconditional redirect of the program counter |
| jump_reg | output | 1 | Jump target is formed from a register |
| alu_op | output | 4 | Operation code for the arithmetic unit |

## Verification
Each result is due in the same cycle as the word that causes it, because no register lies between instr and any output. The bench changes instr at a rising edge and compares all outputs at the next falling edge, half a period later. One check applies a word and compares after a one-time-unit delay with no clock edge, which confirms that no output waits on a clock. For R1, the bench flips only the don't-care bits between two samples and expects the outputs to stay the same.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int ILEN    = 32;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int F7_W    = 7;
  localparam int ALUOP_W = 4;
  localparam int WB_W    = 2;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

  localparam logic [F7_W-1:0] F7_ALT = 7'b0100000;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD  = 4'd0,  ALU_SUB  = 4'd1,  ALU_SLL = 4'd2,  ALU_SLT = 4'd3,
    ALU_SLTU = 4'd4,  ALU_XOR  = 4'd5,  ALU_SRL = 4'd6,  ALU_SRA = 4'd7,
    ALU_OR   = 4'd8,  ALU_AND  = 4'd9,  ALU_CEQ = 4'd10, ALU_CLT = 4'd11,
    ALU_CLTU = 4'd12
  } alu_op_e;

  typedef enum logic [WB_W-1:0] {
    WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC4 = 2'd2
  } wb_sel_e;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_REG, CLS_IMM, CLS_ADDR, CLS_CMP
  } op_class_e;

  typedef struct packed {
    logic    reg_wr;
    logic    b_imm;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    logic    jump_reg;
    wb_sel_e wb;
  } ctrl_t;
endpackage

// File: rtl/instr_fields.sv
module instr_fields
  import instr_dec_pkg::*;
#(
  parameter int W = ILEN
) (
  input  logic [W-1:0]     instr,
  output logic [OPC_W-1:0] opcode,
  output logic [F3_W-1:0]  funct3,
  output logic [F7_W-1:0]  funct7
);
  localparam int OPC_LSB = 0;
  localparam int F3_LSB  = 12;
  localparam int F7_LSB  = W - F7_W;
  localparam int MID_LSB = F3_LSB + F3_W;
  localparam int RD_LSB  = OPC_LSB + OPC_W;

  assign opcode = instr[OPC_LSB +: OPC_W];
  assign funct3 = instr[F3_LSB  +: F3_W];
  assign funct7 = instr[F7_LSB  +: F7_W];

  // register specifiers belong to the register file, not to control
  logic unused_fields;
  assign unused_fields = ^{instr[F7_LSB-1:MID_LSB], instr[F3_LSB-1:RD_LSB]};
endmodule

// File: rtl/ctrl_main.sv
module ctrl_main
  import instr_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl,
  output op_class_e        cls
);
  always_comb begin
    ctrl = '0;
    ctrl.wb = WB_ALU;
    cls  = CLS_NONE;
    unique case (opcode)
      OPC_REG: begin
        ctrl.reg_wr = 1'b1;
        cls = CLS_REG;
      end
      OPC_IMM: begin
        ctrl.reg_wr = 1'b1;
        ctrl.b_imm  = 1'b1;
        cls = CLS_IMM;
      end
      OPC_LOAD: begin
        ctrl.reg_wr = 1'b1;
        ctrl.b_imm  = 1'b1;
        ctrl.mem_rd = 1'b1;
        ctrl.wb     = WB_MEM;
        cls = CLS_ADDR;
      end
      OPC_STORE: begin
        ctrl.b_imm  = 1'b1;
        ctrl.mem_wr = 1'b1;
        cls = CLS_ADDR;
      end
      OPC_BRANCH: begin
        ctrl.branch = 1'b1;
        cls = CLS_CMP;
      end
      OPC_JAL: begin
        ctrl.reg_wr = 1'b1;
        ctrl.jump   = 1'b1;
        ctrl.wb     = WB_PC4;
        cls = CLS_ADDR;
      end
      OPC_JALR: begin
        ctrl.reg_wr   = 1'b1;
        ctrl.jump     = 1'b1;
        ctrl.jump_reg = 1'b1;
        ctrl.b_imm    = 1'b1;
        ctrl.wb       = WB_PC4;
        cls = CLS_ADDR;
      end
      default: begin
        ctrl = '0;
        cls  = CLS_NONE;
      end
    endcase
  end

  always_comb begin
    if (cls == CLS_NONE)
      AST_UNKNOWN_QUIET: assert (ctrl == '0); // R10
    if (ctrl.jump)
      AST_JUMP_LINKS: assert (ctrl.reg_wr && ctrl.wb == WB_PC4); // R8
  end
endmodule

// File: rtl/alu_sel.sv
module alu_sel
  import instr_dec_pkg::*;
(
  input  op_class_e       cls,
  input  logic [F3_W-1:0] funct3,
  input  logic [F7_W-1:0] funct7,
  output alu_op_e         alu_op,
  output logic            cmp_ok
);
  logic    alt;
  alu_op_e arith_op;

  assign alt = (funct7 == F7_ALT);

  // shared arithmetic map; the alternate form of 000 only counts for cls REG
  always_comb begin
    unique case (funct3)
      3'b000:  arith_op = (alt && cls == CLS_REG) ? ALU_SUB : ALU_ADD;
      3'b001:  arith_op = ALU_SLL;
      3'b010:  arith_op = ALU_SLT;
      3'b011:  arith_op = ALU_SLTU;
      3'b100:  arith_op = ALU_XOR;
      3'b101:  arith_op = alt ? ALU_SRA : ALU_SRL;
      3'b110:  arith_op = ALU_OR;
      default: arith_op = ALU_AND;
    endcase
  end

  always_comb begin
    alu_op = ALU_ADD;
    cmp_ok = 1'b0;
    unique case (cls)
      CLS_REG, CLS_IMM: alu_op = arith_op;
      CLS_CMP: begin
        cmp_ok = 1'b1;
        unique case (funct3[2:1])
          2'b00:   alu_op = ALU_CEQ;
          2'b10:   alu_op = ALU_CLT;
          2'b11:   alu_op = ALU_CLTU;
          default: begin
            alu_op = ALU_ADD;
            cmp_ok = 1'b0;
          end
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end

  always_comb begin
    if (cls == CLS_IMM && funct3 == 3'b000)
      AST_IMM_ADD_ONLY: assert (alu_op == ALU_ADD); // R4
    if (cls == CLS_ADDR || cls == CLS_NONE)
      AST_ADDR_ADD: assert (alu_op == ALU_ADD); // R5
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
(
  input  logic [ILEN-1:0]    instr,
  output logic               reg_wr,
  output logic               b_imm,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [WB_W-1:0]    wb_sel,
  output logic               branch,
  output logic               jump,
  output logic               jump_reg,
  output logic [ALUOP_W-1:0] alu_op
);
  logic [OPC_W-1:0] opcode;
  logic [F3_W-1:0]  funct3;
  logic [F7_W-1:0]  funct7;
  ctrl_t            ctrl;
  op_class_e        cls;
  alu_op_e          op_sel;
  logic             cmp_ok;

  instr_fields #(.W(ILEN)) i_fields (
    .instr  (instr),
    .opcode (opcode),
    .funct3 (funct3),
    .funct7 (funct7)
  );

  ctrl_main i_main (
    .opcode (opcode),
    .ctrl   (ctrl),
    .cls    (cls)
  );

  alu_sel i_alu_sel (
    .cls    (cls),
    .funct3 (funct3),
    .funct7 (funct7),
    .alu_op (op_sel),
    .cmp_ok (cmp_ok)
  );

  assign reg_wr   = ctrl.reg_wr;
  assign b_imm    = ctrl.b_imm;
  assign mem_rd   = ctrl.mem_rd;
  assign mem_wr   = ctrl.mem_wr;
  assign wb_sel   = ctrl.wb;
  assign branch   = ctrl.branch & cmp_ok;
  assign jump     = ctrl.jump;
  assign jump_reg = ctrl.jump_reg;
  assign alu_op   = op_sel;

  always_comb begin
    AST_MEM_EXCL: assert (!(mem_rd && mem_wr)); // R11
    AST_REDIRECT_EXCL: assert (!(branch && jump)); // R11
    if (mem_wr)
      AST_STORE_NO_WB: assert (!reg_wr); // R6
    if (branch)
      AST_BRANCH_NO_WB: assert (!reg_wr && !b_imm); // R7
  end
endmodule

// File: tb/test_instr_decoder.sv
module test_instr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'd0;
  logic        reg_wr, b_imm, mem_rd, mem_wr, branch, jump, jump_reg;
  logic [1:0]  wb_sel;
  logic [3:0]  alu_op;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;

  always #5 clk = ~clk;

  instr_decoder i_instr_decoder (
    .instr(instr), .reg_wr(reg_wr), .b_imm(b_imm), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .wb_sel(wb_sel), .branch(branch), .jump(jump),
    .jump_reg(jump_reg), .alu_op(alu_op)
  );

  // packed as {reg_wr,b_imm,mem_rd,mem_wr,wb_sel,branch,jump,jump_reg,alu_op}
  function automatic logic [12:0] pack_out();
    return {reg_wr, b_imm, mem_rd, mem_wr, wb_sel, branch, jump, jump_reg, alu_op};
  endfunction

  function automatic logic [12:0] mk(logic rw, logic bi, logic mr, logic mw,
                                     logic [1:0] wb, logic br, logic j,
                                     logic jr, logic [3:0] op);
    return {rw, bi, mr, mw, wb, br, j, jr, op};
  endfunction

  function automatic logic [3:0] arith(logic [2:0] f3, logic alt, logic reg_form);
    case (f3)
      3'd0: return (alt && reg_form) ? 4'd1 : 4'd0;
      3'd1: return 4'd2;
      3'd2: return 4'd3;
      3'd3: return 4'd4;
      3'd4: return 4'd5;
      3'd5: return alt ? 4'd7 : 4'd6;
      3'd6: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  function automatic logic [12:0] expect_of(logic [31:0] w);
    logic [6:0] opc = w[6:0];
    logic [2:0] f3  = w[14:12];
    logic       alt = (w[31:25] == 7'b0100000);
    case (opc)
      7'b0110011: return mk(1, 0, 0, 0, 2'd0, 0, 0, 0, arith(f3, alt, 1'b1));
      7'b0010011: return mk(1, 1, 0, 0, 2'd0, 0, 0, 0, arith(f3, alt, 1'b0));
      7'b0000011: return mk(1, 1, 1, 0, 2'd1, 0, 0, 0, 4'd0);
      7'b0100011: return mk(0, 1, 0, 1, 2'd0, 0, 0, 0, 4'd0);
      7'b1100011: begin
        if (f3[2:1] == 2'b00) return mk(0, 0, 0, 0, 2'd0, 1, 0, 0, 4'd10);
        if (f3[2:1] == 2'b10) return mk(0, 0, 0, 0, 2'd0, 1, 0, 0, 4'd11);
        if (f3[2:1] == 2'b11) return mk(0, 0, 0, 0, 2'd0, 1, 0, 0, 4'd12);
        return 13'd0;
      end
      7'b1101111: return mk(1, 0, 0, 0, 2'd2, 0, 1, 0, 4'd0);
      7'b1100111: return mk(1, 1, 0, 0, 2'd2, 0, 1, 1, 4'd0);
      default:    return 13'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [6:0] opc);
    case (opc)
      7'b0110011: return "R2/R3";
      7'b0010011: return "R4";
      7'b0000011: return "R5";
      7'b0100011: return "R6";
      7'b1100011: return "R7";
      7'b1101111: return "R8";
      7'b1100111: return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [12:0] act, logic [12:0] exp, logic [31:0] w);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s instr=%08h actual=%013b expected=%013b", tag, w, act, exp);
    end
  endtask

  task automatic apply_check(logic [31:0] w);
    @(posedge clk);
    instr <= w;
    @(negedge clk);
    check(tag_of(w[6:0]), pack_out(), expect_of(w), w);
    check("R11", {11'd0, mem_rd & mem_wr, branch & jump}, 13'd0, w);
  endtask

  function automatic logic [31:0] with_fields(logic [6:0] opc, logic [2:0] f3, logic [6:0] f7);
    logic [31:0] w = $urandom;
    w[6:0] = opc; w[14:12] = f3; w[31:25] = f7;
    return w;
  endfunction

  localparam logic [6:0] OPCS [7] = '{7'b0110011, 7'b0010011, 7'b0000011,
    7'b0100011, 7'b1100011, 7'b1101111, 7'b1100111};

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", pack_out(), 13'd0, instr); // idle word after reset is quiet

    // directed corners: add vs sub, shifts, immediate forms, branch gaps
    apply_check(with_fields(7'b0110011, 3'b000, 7'b0000000)); // R3 add
    apply_check(with_fields(7'b0110011, 3'b000, 7'b0100000)); // R3 sub
    apply_check(with_fields(7'b0110011, 3'b000, 7'b0100001)); // R3 other f7
    apply_check(with_fields(7'b0110011, 3'b101, 7'b0100000)); // R3 sra
    apply_check(with_fields(7'b0010011, 3'b000, 7'b0100000)); // R4 addi stays add
    apply_check(with_fields(7'b0010011, 3'b101, 7'b0100000)); // R4 srai
    apply_check(with_fields(7'b0010011, 3'b101, 7'b0000000)); // R4 srli
    for (int f = 0; f < 8; f++)
      apply_check(with_fields(7'b1100011, 3'(f), 7'd0));      // R7 all compares
    apply_check(with_fields(7'b0000011, 3'b010, 7'd0));       // R5
    apply_check(with_fields(7'b0100011, 3'b010, 7'd0));       // R6
    apply_check(with_fields(7'b1101111, 3'b000, 7'd0));       // R8
    apply_check(with_fields(7'b1100111, 3'b000, 7'd0));       // R9
    apply_check(32'hFFFF_FFFF);                               // R10
    apply_check(32'h0000_0073);                               // R10 system opcode

    // R12: decode settles without any clock edge
    @(negedge clk);
    instr = with_fields(7'b0000011, 3'b000, 7'd0);
    #1;
    check("R12", pack_out(), expect_of(instr), instr);

    // R1: flipping don't-care bits leaves outputs unchanged
    for (int k = 0; k < 40; k++) begin
      logic [31:0] w0, w1;
      logic [12:0] first;
      w0 = with_fields(OPCS[$urandom_range(6)], 3'($urandom), 7'($urandom));
      w1 = w0 ^ ({7'd0, 10'($urandom), 3'd0, 5'($urandom), 7'd0});
      @(posedge clk); instr <= w0;
      @(negedge clk); first = pack_out();
      @(posedge clk); instr <= w1;
      @(negedge clk); check("R1", pack_out(), first, w1);
    end

    // constrained random: mostly supported opcodes, some arbitrary ones
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w = $urandom;
      if ($urandom_range(9) < 8) w[6:0] = OPCS[$urandom_range(6)];
      if ($urandom_range(3) == 0) w[31:25] = 7'b0100000;
      apply_check(w);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule